// File: doc/BRIEF.md
# Oversampling Manchester Line Decoder

This block recovers data bits from a Manchester-coded serial line that comes without a clock. A sample tick, running at a fixed multiple of the bit rate (nominally twelve samples per bit), qualifies the line input. The block does not XOR the line against a recovered clock. It measures how many equal samples follow one another. Each such run is classified as one half-bit or as two half-bits of the same level. Two runs of two levels form a bit, and the order of the levels within the bit gives its value. A run whose length fits neither window marks the bit period as malformed.

A capture starts on the first low sample that follows a high sample while the block is idle. A capture lasts a programmed number of samples, given as count minus one in an 8-bit value, so one capture holds at most 256 samples. At twelve samples per bit that is room for 21 bits. Decoded bits appear one by one with a valid strobe. A done pulse ends the capture, and an error flag holds until the next capture begins. Firmware buffering and frame parsing sit outside this block.

Top module: `manch_os_rx`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `bit_valid`, `frame_done` and `bit_err` are 0.
- R2: A capture starts only on a ticked sample of 0 whose preceding ticked sample was 1, and only while no capture is running. A line held low from reset starts nothing.
- R3: With `conv_sel`=0, a bit whose first half is low and second half is high decodes to 1, and high-then-low decodes to 0. With `conv_sel`=1 both values are inverted. Bits leave in line order.
- R4: A run of equal samples with length in [`win_lo`, `win_hi`] counts as one half-bit. A run with length in [2·`win_lo`, 2·`win_hi`] counts as two half-bits of that level. Settings must keep `win_hi` < 2·`win_lo` and `win_lo` ≥ 2.
- R5: `bit_err` goes to 1 in three cases: a run that fits neither window, a bit whose two halves share a level, or a double run without a pending first half. It then stays 1 until the next capture start clears it.
- R6: A capture takes exactly `sample_limit`+1 ticked samples, counting the start sample. `frame_done` pulses for one clock, one clock after the last of them. At that point a final run shorter than `win_lo` is discarded without error.
- R7: The line is read only on clocks with `sample_tick`=1. Line changes on other clocks have no effect.
- R8: `bit_valid` is a one-clock pulse. It comes one clock after the tick whose sample ends the bit's second half: either the first sample of the next level or the last sample of the capture. `bit_out` holds its value between pulses.
- R9: A 21-bit frame at 12 samples per bit (252 samples) decodes completely within one capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_tick | input | 1 | Qualifies `line_in` as one sample on this clock |
| line_in | input | 1 | Manchester line, already synchronous to `clk` |
| conv_sel | input | 1 | Bit value convention select (R3) |
| sample_limit | input | CNT_W | Samples per capture minus one |
| win_lo | input | RUN_W | Shortest accepted half-bit run |
| win_hi | input | RUN_W | Longest accepted half-bit run |
| bit_out | output | 1 | Last decoded bit |
| bit_valid | output | 1 | One-clock strobe for `bit_out` |
| frame_done | output | 1 | One-clock pulse at the end of a capture |
| bit_err | output | 1 | Malformed bit period seen in this capture |

## Verification
Each result is due one clock after the tick that causes it. `bit_valid` follows the tick carrying the first sample of the next level, or the final sample. `frame_done` follows the tick carrying sample number `sample_limit`+1. `bit_err` is set after the offending run ends and is read once the frame is over. The bench raises the tick on every other clock and samples outputs at the falling edge between ticks. It counts ticks from the capture start, so the tick index at which the first bit and the done pulse appear is compared with the value the requirements give.

// File: rtl/mos_pkg.sv
package mos_pkg;

    // Classification of one completed run of equal samples
    typedef enum logic [1:0] {
        RUN_NONE = 2'd0,
        RUN_HALF = 2'd1,
        RUN_PAIR = 2'd2,
        RUN_BAD  = 2'd3
    } run_kind_e;

    typedef struct packed {
        logic      lvl;
        run_kind_e kind;
    } run_evt_t;

    // Value of a bit given the level of its first half
    function automatic logic decode_bit(input logic first_lvl, input logic conv);
        return first_lvl ^ ~conv;
    endfunction

endpackage

// File: rtl/mos_frame_ctl.sv
module mos_frame_ctl #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             line,
    input  logic [CNT_W-1:0] limit,
    output logic             take,
    output logic             first,
    output logic             last
);
    logic             capturing;
    logic             prev_hi;
    logic [CNT_W-1:0] cnt;
    logic             start;
    logic             in_cap;

    always_comb begin
        start  = tick & ~capturing & prev_hi & ~line;
        in_cap = tick & capturing;
        take   = start | in_cap;
        first  = start;
        last   = (start && (limit == '0)) || (in_cap && (cnt == limit));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            capturing <= 1'b0;
            prev_hi   <= 1'b0;
            cnt       <= '0;
        end else begin
            if (tick) prev_hi <= line;
            if (start) begin
                capturing <= ~last;
                cnt       <= CNT_W'(1);
            end else if (in_cap) begin
                if (last) capturing <= 1'b0;
                else      cnt       <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mos_run_track.sv
module mos_run_track
    import mos_pkg::*;
#(
    parameter int RUN_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             first,
    input  logic             last,
    input  logic             smp,
    input  logic [RUN_W-1:0] lo,
    input  logic [RUN_W-1:0] hi,
    output run_evt_t         evt
);
    logic             run_lvl;
    logic [RUN_W-1:0] run_len;
    logic [RUN_W-1:0] len_inc;

    function automatic run_kind_e classify(input logic [RUN_W-1:0] len,
                                           input logic [RUN_W-1:0] wl,
                                           input logic [RUN_W-1:0] wh,
                                           input logic             fin);
        logic [RUN_W:0] l_ext;
        logic [RUN_W:0] wl2;
        logic [RUN_W:0] wh2;
        l_ext = {1'b0, len};
        wl2   = {wl, 1'b0};
        wh2   = {wh, 1'b0};
        if (fin && (len < wl))             return RUN_NONE;
        if ((len >= wl) && (len <= wh))    return RUN_HALF;
        if ((l_ext >= wl2) && (l_ext <= wh2)) return RUN_PAIR;
        return RUN_BAD;
    endfunction

    always_comb begin
        len_inc  = (run_len == '1) ? run_len : run_len + 1'b1;
        evt.lvl  = run_lvl;
        evt.kind = RUN_NONE;
        if (take && !first) begin
            if (smp != run_lvl) evt.kind = classify(run_len, lo, hi, 1'b0);
            else if (last)      evt.kind = classify(len_inc, lo, hi, 1'b1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_lvl <= 1'b1;
            run_len <= '0;
        end else if (take) begin
            if (first || (smp != run_lvl)) begin
                run_lvl <= smp;
                run_len <= RUN_W'(1);
            end else begin
                run_len <= len_inc;
            end
        end
    end
endmodule

// File: rtl/mos_half_pair.sv
module mos_half_pair
    import mos_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     first,
    input  logic     last,
    input  logic     conv,
    input  run_evt_t evt,
    output logic     bit_out,
    output logic     bit_valid,
    output logic     frame_done,
    output logic     bit_err
);
    logic pend;
    logic held_lvl;
    logic emit;
    logic err;
    logic npend;
    logic nheld;

    always_comb begin
        emit  = 1'b0;
        err   = 1'b0;
        npend = pend;
        nheld = held_lvl;
        case (evt.kind)
            RUN_HALF: begin
                if (pend) begin
                    npend = 1'b0;
                    if (held_lvl != evt.lvl) emit = 1'b1;
                    else                     err  = 1'b1;
                end else begin
                    npend = 1'b1;
                    nheld = evt.lvl;
                end
            end
            RUN_PAIR: begin
                if (pend && (held_lvl != evt.lvl)) begin
                    emit  = 1'b1;
                    npend = 1'b1;
                    nheld = evt.lvl;
                end else begin
                    err   = 1'b1;
                    npend = 1'b0;
                end
            end
            RUN_BAD: begin
                err   = 1'b1;
                npend = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend       <= 1'b0;
            held_lvl   <= 1'b0;
            bit_out    <= 1'b0;
            bit_valid  <= 1'b0;
            frame_done <= 1'b0;
            bit_err    <= 1'b0;
        end else begin
            bit_valid  <= emit;
            frame_done <= last;
            if (emit) bit_out <= decode_bit(held_lvl, conv);
            if (first) begin
                pend    <= 1'b0;
                bit_err <= 1'b0;
            end else begin
                pend     <= npend;
                held_lvl <= nheld;
                if (err) bit_err <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/manch_os_rx.sv
module manch_os_rx
    import mos_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int RUN_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_tick,
    input  logic             line_in,
    input  logic             conv_sel,
    input  logic [CNT_W-1:0] sample_limit,
    input  logic [RUN_W-1:0] win_lo,
    input  logic [RUN_W-1:0] win_hi,
    output logic             bit_out,
    output logic             bit_valid,
    output logic             frame_done,
    output logic             bit_err
);
    logic     take;
    logic     first;
    logic     last;
    run_evt_t evt;

    mos_frame_ctl #(.CNT_W(CNT_W)) u_ctl (
        .clk   (clk),
        .rst   (rst),
        .tick  (sample_tick),
        .line  (line_in),
        .limit (sample_limit),
        .take  (take),
        .first (first),
        .last  (last)
    );

    mos_run_track #(.RUN_W(RUN_W)) u_run (
        .clk   (clk),
        .rst   (rst),
        .take  (take),
        .first (first),
        .last  (last),
        .smp   (line_in),
        .lo    (win_lo),
        .hi    (win_hi),
        .evt   (evt)
    );

    mos_half_pair u_pair (
        .clk        (clk),
        .rst        (rst),
        .first      (first),
        .last       (last),
        .conv       (conv_sel),
        .evt        (evt),
        .bit_out    (bit_out),
        .bit_valid  (bit_valid),
        .frame_done (frame_done),
        .bit_err    (bit_err)
    );
endmodule

// File: rtl/mos_rx_chk.sv
module mos_rx_chk (
    input logic clk,
    input logic rst,
    input logic sample_tick,
    input logic bit_out,
    input logic bit_valid,
    input logic frame_done,
    input logic bit_err
);
    // R1: outputs quiet one clock into reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!bit_valid && !frame_done && !bit_err));

    // R7: nothing is produced from a clock without a tick
    p_no_tick_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !sample_tick |=> (!bit_valid && !frame_done));

    // R8: bit strobe lasts one clock
    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        bit_valid |=> !bit_valid);

    // R8: bit value holds when no sample is taken
    p_bit_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !sample_tick |=> $stable(bit_out));

    // R6: done lasts one clock
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    // R5: error stays set until a ticked sample can clear it
    p_err_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (bit_err && !sample_tick) |=> bit_err);
endmodule

bind manch_os_rx mos_rx_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .sample_tick (sample_tick),
    .bit_out     (bit_out),
    .bit_valid   (bit_valid),
    .frame_done  (frame_done),
    .bit_err     (bit_err)
);

// File: tb/manch_os_rx_test.sv
module manch_os_rx_test;
    localparam int CLK_P = 10;

    typedef struct packed {
        logic [4:0]  n;
        logic [20:0] data;
        logic        conv;
        logic [3:0]  hl;
        logic [5:0]  lo;
        logic [5:0]  hi;
        logic        exp_err;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{5'd8,  21'h0000B5, 1'b0, 4'd6, 6'd4, 6'd7, 1'b0},
        '{5'd8,  21'h00004A, 1'b1, 4'd6, 6'd4, 6'd7, 1'b0},
        '{5'd21, 21'h15A3C7, 1'b0, 4'd6, 6'd4, 6'd7, 1'b0},
        '{5'd10, 21'h000333, 1'b0, 4'd4, 6'd4, 6'd7, 1'b0},
        '{5'd10, 21'h0002CD, 1'b0, 4'd7, 6'd4, 6'd7, 1'b0},
        '{5'd6,  21'h000015, 1'b0, 4'd3, 6'd4, 6'd7, 1'b1},
        '{5'd6,  21'h00002D, 1'b0, 4'd4, 6'd5, 6'd7, 1'b1},
        '{5'd12, 21'h000A52, 1'b1, 4'd5, 6'd4, 6'd7, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sample_tick = 1'b0;
    logic       line_in = 1'b0;
    logic       conv_sel = 1'b0;
    logic [7:0] sample_limit = 8'd0;
    logic [5:0] win_lo = 6'd4;
    logic [5:0] win_hi = 6'd7;
    logic       bit_out, bit_valid, frame_done, bit_err;

    int checks = 0;
    int errors = 0;
    int n_push = 0;
    int got_n = 0;
    int first_at = 0;
    int done_cnt = 0;
    int done_at = 0;
    logic [31:0] got_bits = '0;
    bit finished = 1'b0;

    manch_os_rx uut (
        .clk          (clk),
        .rst          (rst),
        .sample_tick  (sample_tick),
        .line_in      (line_in),
        .conv_sel     (conv_sel),
        .sample_limit (sample_limit),
        .win_lo       (win_lo),
        .win_hi       (win_hi),
        .bit_out      (bit_out),
        .bit_valid    (bit_valid),
        .frame_done   (frame_done),
        .bit_err      (bit_err)
    );

    always #(CLK_P/2) clk = ~clk;

    // Output monitor on the falling edge
    always @(negedge clk) begin
        if (!rst && bit_valid) begin
            if (got_n == 0) first_at = n_push;
            if (got_n < 32) got_bits[got_n] = bit_out;
            got_n = got_n + 1;
        end
        if (!rst && frame_done) begin
            done_cnt = done_cnt + 1;
            done_at  = n_push;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // One sample: tick on one clock, quiet clock after (optionally with a line glitch)
    task automatic push(input logic lvl, input bit glitch);
        @(negedge clk);
        line_in     = lvl;
        sample_tick = 1'b1;
        n_push++;
        @(negedge clk);
        sample_tick = 1'b0;
        if (glitch) line_in = ~lvl;
    endtask

    task automatic send_frame(input int n, input logic [20:0] data, input logic conv,
                              input int hl, input int limit, input bit glitch);
        logic fl;
        conv_sel     = conv;
        sample_limit = 8'(limit);
        got_n = 0; got_bits = '0; done_cnt = 0; done_at = 0; first_at = 0;
        for (int k = 0; k < 3; k++) push(1'b1, 1'b0);
        n_push = 0;
        for (int b = 0; b < n; b++) begin
            fl = data[b] ^ ~conv;
            for (int s = 0; s < hl; s++) push(fl, glitch);
            for (int s = 0; s < hl; s++) push(~fl, glitch);
        end
        for (int k = 0; k < 3; k++) push(1'b1, 1'b0);
    endtask

    function automatic int mask_of(input int n, input logic [31:0] v);
        logic [31:0] m;
        m = (32'd1 << n) - 32'd1;
        return int'(v & m);
    endfunction

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int lim;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!bit_valid && !frame_done && !bit_err, "R1 reset outputs",
              {bit_valid, frame_done, bit_err}, 0);
        rst = 1'b0;

        // R2: line held low from reset starts no capture
        for (int k = 0; k < 6; k++) push(1'b0, 1'b0);
        check(done_cnt == 0 && got_n == 0, "R2 no start without high", done_cnt + got_n, 0);

        // Table walk: R3, R4, R5, R6, R9
        for (int v = 0; v < NV; v++) begin
            win_lo = VECS[v].lo;
            win_hi = VECS[v].hi;
            lim = int'(VECS[v].n) * 2 * int'(VECS[v].hl) - 1;
            send_frame(int'(VECS[v].n), VECS[v].data, VECS[v].conv, int'(VECS[v].hl), lim, 1'b0);
            check(done_cnt == 1, "R6 one done pulse", done_cnt, 1);
            check(done_at == lim + 1, "R6 done after limit+1 samples", done_at, lim + 1);
            check(bit_err == VECS[v].exp_err, "R5 error flag", int'(bit_err), int'(VECS[v].exp_err));
            if (!VECS[v].exp_err) begin
                // R4 halves/double runs, R9 for the 21-bit vector
                check(got_n == int'(VECS[v].n), "R4 R9 bit count", got_n, int'(VECS[v].n));
                check(mask_of(got_n, got_bits) == int'(VECS[v].data), "R3 decoded bits",
                      mask_of(got_n, got_bits), int'(VECS[v].data));
            end
        end

        // R8: first bit strobe timing on all-ones frame (edge every half)
        win_lo = 6'd4; win_hi = 6'd7;
        send_frame(4, 21'h00000F, 1'b0, 6, 47, 1'b0);
        check(first_at == 13, "R8 first bit after sample 13", first_at, 13);
        check(got_n == 4 && mask_of(4, got_bits) == 15, "R3 all ones", mask_of(4, got_bits), 15);

        // R7: glitches on non-tick clocks are ignored
        send_frame(8, 21'h0000B5, 1'b0, 6, 95, 1'b1);
        check(got_n == 8 && mask_of(8, got_bits) == 'hB5, "R7 glitch ignored",
              mask_of(8, got_bits), 'hB5);
        check(!bit_err, "R7 no error from glitch", int'(bit_err), 0);

        // R6: truncated capture drops a short final run without error
        send_frame(8, 21'h0000B5, 1'b0, 6, 92, 1'b0);
        check(done_at == 93, "R6 truncated done", done_at, 93);
        check(got_n == 7 && mask_of(7, got_bits) == 'h35, "R6 short final run dropped",
              mask_of(7, got_bits), 'h35);
        check(!bit_err, "R6 no error on truncation", int'(bit_err), 0);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule